// File: doc/BRIEF.md
# Dual-Read Register File with Constant-Zero Top Register

This block is the general-register store of a 32-bit load-store processor core. It holds thirty-two words of 32 bits each, addressed by 5-bit indices. Two independent read ports return both source operands of an instruction in the same cycle, without waiting on a clock. A single write port stores the destination result at the rising clock edge.

The highest-numbered register is not storage. It reads as zero on both ports at all times, and writes addressed to it are dropped. Software can therefore use it as a zero source and as a destination that discards a result. A synchronous active-high reset clears every real register.

Widths and depth are parameters. A mode parameter can remove the constant-zero register, which turns the top index into an ordinary register. The defaults match the 32 x 32 organisation described above.

Top module: `zreg_file`

## Requirements
- R1: The file holds 32 registers of 32 bits. A 5-bit index value n selects register n for reading and for writing, so index 0b00000 selects register 0.
- R2: The two read ports are independent and combinational. Each output shows the current contents of the register its own index selects, in the same cycle the index is applied.
- R3: Index 31 reads as 0x00000000 on both read ports, whatever was written to it before.
- R4: A write with index 31 changes no register. Every register keeps its value and index 31 still reads 0.
- R5: When the write enable is 1 at a rising clock edge and the write index is not 31, the addressed register takes the write data.
- R6: When the write enable is 0 at a rising clock edge, no register changes, whatever the write index and write data are.
- R7: A read of the register being written returns the old value during the write cycle. The new value appears from the cycle after the edge.
- R8: Reset is synchronous and active high. At a rising edge with reset at 1, registers 0 to 30 become 0. Before that edge the read ports still show the old contents.
- R9: Reset takes priority over the write port. A write presented in a reset cycle is lost, and the register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Data to store |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Contents of the register selected on port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Contents of the register selected on port B |

## Verification
Every register below 31 is written with a value built from its own index. The registers are then read in pairs of mirrored indices. A swapped, stuck or aliased address bit on either port shows up as a wrong value, and so does a port that follows the other port's index. All-ones, alternating-bit and zero data separate bit-level faults from faults in selection. Directed writes to index 31, writes with the enable low, and reads of the register being written test the discard path, the enable gating and the read-before-write ordering. Long pseudo-random streams then mix all of these against a reference array, and reset is checked both before and at its edge, including a reset that meets a pending write.

// File: rtl/zrf_pkg.sv
package zrf_pkg;

   typedef enum logic [0:0] {
      ZERO_AT_TOP = 1'b0,
      ZERO_NONE   = 1'b1
   } zero_mode_e;

   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/zrf_storage.sv
module zrf_storage
   import zrf_pkg::*;
#(
   parameter int         NUM_REGS = 32,
   parameter int         DATA_W   = 32,
   parameter zero_mode_e ZMODE    = ZERO_AT_TOP,
   localparam int        IDX_W    = idx_width(NUM_REGS)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   rows
);

   localparam int  ZERO_IDX = NUM_REGS - 1;
   localparam bit  HAS_ZERO = (ZMODE == ZERO_AT_TOP);

   logic [NUM_REGS-1:0] row_we;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_row
      assign row_we[i] = wr_en && (wr_idx == IDX_W'(i));

      if (HAS_ZERO && (i == ZERO_IDX)) begin : g_const
         assign rows[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (row_we[i])
               q <= wr_data;
         end
         assign rows[i] = q;
      end
   end

   logic wr_real;
   assign wr_real = wr_en && !(HAS_ZERO && (wr_idx == IDX_W'(ZERO_IDX)));

   // R5: a real write lands in the addressed row
   a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
      wr_real |=> rows[$past(wr_idx)] == $past(wr_data));

   // R6: no enable, no change
   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(rows));

   // R4: a write to the constant register touches nothing
   a_r4_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
      (wr_en && HAS_ZERO && (wr_idx == IDX_W'(ZERO_IDX))) |=> $stable(rows));

   // R8 and R9: reset clears the array and wins over a write
   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (rows == '0));

endmodule

// File: rtl/zrf_read_port.sv
module zrf_read_port
   import zrf_pkg::*;
#(
   parameter int         NUM_REGS = 32,
   parameter int         DATA_W   = 32,
   parameter zero_mode_e ZMODE    = ZERO_AT_TOP,
   localparam int        IDX_W    = idx_width(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
   input  logic [IDX_W-1:0]                idx,
   output logic [DATA_W-1:0]               data
);

   localparam int ZERO_IDX = NUM_REGS - 1;

   logic in_range;
   assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));

   if (ZMODE == ZERO_AT_TOP) begin : g_zero_mask
      always_comb begin
         if (!in_range || (idx == IDX_W'(ZERO_IDX)))
            data = '0;
         else
            data = rows[idx];
      end
   end else begin : g_plain
      always_comb begin
         if (!in_range)
            data = '0;
         else
            data = rows[idx];
      end
   end

endmodule

// File: rtl/zreg_file.sv
module zreg_file
   import zrf_pkg::*;
#(
   parameter int         NUM_REGS = 32,
   parameter int         DATA_W   = 32,
   parameter zero_mode_e ZMODE    = ZERO_AT_TOP,
   localparam int        IDX_W    = idx_width(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);

   localparam int ZERO_IDX = NUM_REGS - 1;
   localparam bit HAS_ZERO = (ZMODE == ZERO_AT_TOP);

   if (NUM_REGS < 2) begin : g_bad_depth
      $error("zreg_file: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("zreg_file: DATA_W must be at least 1");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] rows;

   zrf_storage #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ZMODE    (ZMODE)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rows    (rows)
   );

   zrf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ZMODE    (ZMODE)
   ) u_port_a (
      .rows (rows),
      .idx  (rd_idx_a),
      .data (rd_data_a)
   );

   zrf_read_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .ZMODE    (ZMODE)
   ) u_port_b (
      .rows (rows),
      .idx  (rd_idx_b),
      .data (rd_data_b)
   );

   // R3: the constant register reads zero on both ports
   a_r3_zero_on_a: assert property (@(posedge clk) disable iff (rst)
      (HAS_ZERO && (rd_idx_a == IDX_W'(ZERO_IDX))) |-> (rd_data_a == '0));
   a_r3_zero_on_b: assert property (@(posedge clk) disable iff (rst)
      (HAS_ZERO && (rd_idx_b == IDX_W'(ZERO_IDX))) |-> (rd_data_b == '0));

   // R7: a value written now is seen on a port that keeps its index
   a_r7_new_value_next: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx == rd_idx_a) && !(HAS_ZERO && (wr_idx == IDX_W'(ZERO_IDX))))
      |=> ((rd_idx_a != $past(rd_idx_a)) || (rd_data_a == $past(wr_data))));

endmodule

// File: tb/zreg_file_bench.sv
module zreg_file_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 32;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam int ZI = NR - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          we  = 1'b0;
   logic [AW-1:0] wa  = '0;
   logic [DW-1:0] wd  = '0;
   logic [AW-1:0] ra1 = '0;
   logic [AW-1:0] ra2 = '0;
   logic [DW-1:0] rd1;
   logic [DW-1:0] rd2;

   logic [DW-1:0] model [NR];
   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   always #(CLK_PERIOD/2) clk = ~clk;

   zreg_file u_zreg_file (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (we),
      .wr_idx    (wa),
      .wr_data   (wd),
      .rd_idx_a  (ra1),
      .rd_data_a (rd1),
      .rd_idx_b  (ra2),
      .rd_data_b (rd2)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < NR; i++) model[i] = '0;
   endtask

   // drive one cycle, check both ports before the edge, update the model at the edge
   task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [AW-1:0] r1, input logic [AW-1:0] r2, input string tag);
      @(negedge clk);
      we = w; wa = a; wd = d; ra1 = r1; ra2 = r2;
      #1;
      chk({tag, " port A"}, rd1, model[r1]);
      chk({tag, " port B"}, rd2, model[r2]);
      @(posedge clk);
      if (w && (a != AW'(ZI))) model[a] = d;
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < NR; i++) cyc(1'b0, '0, '0, AW'(i), AW'(NR-1-i), tag);
   endtask

   function automatic logic [DW-1:0] tag_val(input int i);
      return {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'h3C};
   endfunction

   task automatic t_reset_state();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      clear_model();
      read_all("R8 reset state");
   endtask

   task automatic t_index_map();
      for (int i = 0; i < ZI; i++) cyc(1'b1, AW'(i), tag_val(i), AW'(i), AW'(ZI), "R1 R5 fill");
      for (int i = 0; i < NR; i++) cyc(1'b0, '0, '0, AW'(i), AW'(30 - (i % 31)), "R1 R2 mirrored read");
      cyc(1'b0, '0, '0, 5'd0, 5'd0, "R1 index zero is register 0");
      chk("R1 register 0 value", rd1, tag_val(0));
   endtask

   task automatic t_zero_reg();
      cyc(1'b1, AW'(ZI), 32'hFFFF_FFFF, AW'(ZI), 5'd4, "R4 write to 31");
      cyc(1'b0, '0, '0, AW'(ZI), AW'(ZI), "R3 reads zero after write");
      chk("R3 port A at index 31", rd1, 32'h0);
      read_all("R4 nothing disturbed");
   endtask

   task automatic t_idle_write();
      cyc(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd6, "R6 enable low");
      cyc(1'b0, 5'd0, '0, 5'd5, 5'd5, "R6 register 5 kept");
      chk("R6 register 5 value", rd1, tag_val(5));
   endtask

   task automatic t_same_cycle();
      cyc(1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd7, "R7 old value during write");
      chk("R7 old value", rd2, tag_val(7));
      cyc(1'b0, '0, '0, 5'd7, 5'd8, "R7 new value next cycle");
      chk("R7 new value", rd1, 32'h1234_5678);
   endtask

   task automatic t_patterns();
      cyc(1'b1, 5'd10, 32'hFFFF_FFFF, 5'd10, 5'd11, "R5 all ones");
      cyc(1'b1, 5'd11, 32'h5555_5555, 5'd10, 5'd11, "R5 alt 55");
      cyc(1'b1, 5'd12, 32'hAAAA_AAAA, 5'd11, 5'd12, "R5 alt AA");
      cyc(1'b1, 5'd30, 32'h0000_0000, 5'd12, 5'd30, "R5 zero data");
      cyc(1'b0, '0, '0, 5'd30, 5'd12, "R5 readback");
   endtask

   task automatic t_random(input int n);
      for (int k = 0; k < n; k++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         cyc(lfsr[0], lfsr[5:1], {lfsr[15:0], lfsr[31:16]} ^ 32'h9E37_79B9,
             lfsr[10:6], lfsr[15:11], "R2 R5 R7 random");
      end
   endtask

   task automatic t_sync_reset();
      @(negedge clk);
      rst = 1'b1; we = 1'b1; wa = 5'd3; wd = 32'hCAFE_0003; ra1 = 5'd3; ra2 = 5'd30;
      #1;
      chk("R8 port A before reset edge", rd1, model[3]);
      chk("R8 port B before reset edge", rd2, model[30]);
      @(posedge clk);
      clear_model();
      @(negedge clk);
      rst = 1'b0; we = 1'b0;
      #1;
      chk("R9 write lost in reset", rd1, 32'h0);
      read_all("R8 cleared");
   endtask

   initial begin
      clear_model();
      t_reset_state();
      t_index_map();
      t_zero_reg();
      t_idle_write();
      t_same_cycle();
      t_patterns();
      t_random(3000);
      t_sync_reset();
      t_random(1000);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule